// File: doc/BRIEF.md
# Serial Command-Port Resync Detector

This block is the device side of a four-wire serial port, sitting in front of a command decoder. The port is active while the chip-select input is low. On each rising edge of the serial clock it takes one bit from the serial data input, most significant bit first, and builds eight-bit bytes. Completed command bytes go to the decoder as a one-cycle strobe with the byte value. The serial clock, chip select and data are asynchronous to the system clock, so the block brings them into the system clock domain and finds the clock edges there.

A host can lose byte alignment with the port, for example after a glitch or an aborted transfer. To recover, the host sends fifteen 0xFF bytes followed by one 0xFE byte. The block watches for this as a bit pattern: 127 one-bits in a row followed by a zero-bit. It therefore finds the pattern even when the stream is not aligned to byte boundaries. When it finds the pattern, it emits a one-cycle resync pulse and restarts byte assembly, so the next bit begins a fresh byte. Because 0xFF is used only as fill, 0xFF bytes are never passed to the decoder as commands.

The serial output is a tri-state pad. Its enable is low whenever chip select is high, and while chip select is low the pad carries the bit supplied by the decoder.

Top module: `cmd_port_resync`

## Requirements
- R1: After reset, `cmd_valid` and `resync_pulse` are 0 and `cmd_byte` is 0x00. The bit position is at the start of a byte.
- R2: While `csn_in` is low, each rising edge of `sclk_in` samples `sdi_in`, most significant bit first. After the eighth bit, a byte other than 0xFF appears on `cmd_byte` with `cmd_valid` high for exactly one cycle. This happens in the third system clock after the clock edge that sees the eighth serial clock rise.
- R3: Serial clock edges that occur while `csn_in` is high take no bit and do not advance the bit position.
- R4: `sdo_oe` is 0 whenever `csn_in` is 1. While `csn_in` is 0, `sdo_oe` is 1 and `sdo_o` equals `tx_bit`. While `csn_in` is 1, `sdo_o` is 0.
- R5: A completed byte equal to 0xFF never raises `cmd_valid`.
- R6: Fifteen aligned 0xFF bytes followed by 0xFE (127 one-bits, then a zero-bit) raise `resync_pulse` for one cycle. The closing 0xFE is not forwarded.
- R7: A run of more than fifteen 0xFF bytes followed by 0xFE also causes exactly one resync.
- R8: Fewer than fifteen 0xFF bytes followed by 0xFE cause no resync. The 0xFE is forwarded as a command.
- R9: The resync pattern is found even when it starts in the middle of a byte. After the resync, the next eight bits form one byte.
- R10: A byte other than 0xFF that breaks the run of 0xFF bytes clears it. A 0xFE that follows fewer than fifteen 0xFF bytes after the break is forwarded, and no resync occurs.
- R11: `cmd_valid` and `resync_pulse` are never high in the same cycle. `cmd_byte` changes only in a cycle where `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| csn_in | input | 1 | Active-low chip select, asynchronous |
| sdi_in | input | 1 | Serial data from the host |
| tx_bit | input | 1 | Bit the decoder wants driven on the serial output |
| sdo_o | output | 1 | Serial output data to the pad |
| sdo_oe | output | 1 | Serial output pad enable; 0 means high impedance |
| cmd_valid | output | 1 | One-cycle strobe: a command byte is on `cmd_byte` |
| cmd_byte | output | 8 | Last forwarded command byte |
| resync_pulse | output | 1 | One-cycle strobe: resync pattern found, port back in command mode |

## Verification
A wrong bit position inside the block does not show up at the ports until the next byte completes. At that point the forwarded value is shifted, or a strobe lands a few serial bits early or late, so a reference model that checks every cycle catches it within about eight serial clocks. A wrong count of consecutive one-bits shows up only at the end of a sync run: a resync pulse is missing or spurious, or a 0xFE byte is wrongly forwarded or dropped. For that reason the run lengths are tested on both sides of fifteen, and the run is also started mid-byte. A fault in the pad enable shows up at once, because `sdo_oe` is compared with `csn_in` on every clock.

// File: rtl/cmdport_pkg.sv
`timescale 1ns/1ps
package cmdport_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] cp_byte_t;
  // fill byte used by the host for padding and for the resync run
  localparam cp_byte_t FILL_BYTE = 8'hFF;
endpackage

// File: rtl/cp_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage synchronizer for independent asynchronous inputs
module cp_sync #(
  parameter int          W        = 1,
  parameter int          STAGES   = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/cp_front.sv
`timescale 1ns/1ps
// Brings serial pins into the system domain and finds sampling edges
module cp_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic csn_in,
  input  logic sdi_in,
  output logic bit_stb,
  output logic bit_val
);
  logic [2:0] pins_s;   // {sclk, csn, sdi}
  logic       sclk_prev_q;
  logic       sclk_prev_d;

  cp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk_in, csn_in, sdi_in}),
    .q     (pins_s)
  );

  always_comb begin
    sclk_prev_d = pins_s[2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_prev_d;
  end

  // rising serial clock while selected
  assign bit_stb = pins_s[2] & ~sclk_prev_q & ~pins_s[1];
  assign bit_val = pins_s[0];
endmodule

// File: rtl/cp_bytes.sv
`timescale 1ns/1ps
// Bit position counter and byte shift register with realignment
module cp_bytes #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              realign,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] shreg_q, shreg_d;

  always_comb begin
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    if (bit_stb) begin
      shreg_d = {shreg_q[BYTE_W-3:0], bit_val};
      if (realign || cnt_q == LAST) cnt_d = '0;
      else                          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
    end
  end

  assign byte_done = bit_stb & (cnt_q == LAST);
  assign byte_val  = {shreg_q, bit_val};
endmodule

// File: rtl/cp_resync.sv
`timescale 1ns/1ps
// Counts consecutive one-bits; a zero after enough ones is the resync mark
module cp_resync #(
  parameter int RUN_BYTES = 15,
  parameter int BYTE_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  output logic hit
);
  localparam int THR = RUN_BYTES * BYTE_W + BYTE_W - 1;
  localparam int CW  = $clog2(THR + 1);
  localparam logic [CW-1:0] THR_C = CW'(THR);

  logic [CW-1:0] ones_q, ones_d;

  always_comb begin
    ones_d = ones_q;
    if (bit_stb) begin
      if (!bit_val)            ones_d = '0;
      else if (ones_q != THR_C) ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end

  assign hit = bit_stb & ~bit_val & (ones_q == THR_C);
endmodule

// File: rtl/cmd_port_resync.sv
`timescale 1ns/1ps
module cmd_port_resync
  import cmdport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RUN_BYTES   = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_in,
  input  logic        csn_in,
  input  logic        sdi_in,
  input  logic        tx_bit,
  output logic        sdo_o,
  output logic        sdo_oe,
  output logic        cmd_valid,
  output logic [7:0]  cmd_byte,
  output logic        resync_pulse
);
  logic     bit_stb, bit_val;
  logic     byte_done, hit, fwd;
  cp_byte_t byte_val;

  logic     cmd_valid_q, cmd_valid_d;
  logic     resync_q, resync_d;
  cp_byte_t cmd_byte_q, cmd_byte_d;

  cp_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .csn_in  (csn_in),
    .sdi_in  (sdi_in),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  cp_bytes #(.BYTE_W(BYTE_W)) i_bytes (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bit_stb),
    .bit_val   (bit_val),
    .realign   (hit),
    .byte_done (byte_done),
    .byte_val  (byte_val)
  );

  cp_resync #(.RUN_BYTES(RUN_BYTES), .BYTE_W(BYTE_W)) i_resync (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .hit     (hit)
  );

  assign fwd = byte_done & ~hit & (byte_val != FILL_BYTE);

  always_comb begin
    cmd_valid_d = fwd;
    resync_d    = hit;
    cmd_byte_d  = cmd_byte_q;
    if (fwd) cmd_byte_d = byte_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_q <= 1'b0;
      resync_q    <= 1'b0;
      cmd_byte_q  <= '0;
    end else begin
      cmd_valid_q <= cmd_valid_d;
      resync_q    <= resync_d;
      cmd_byte_q  <= cmd_byte_d;
    end
  end

  // pad enable follows the raw select pin so the pad floats at once
  assign sdo_oe       = ~csn_in;
  assign sdo_o        = tx_bit & ~csn_in;
  assign cmd_valid    = cmd_valid_q;
  assign cmd_byte     = cmd_byte_q;
  assign resync_pulse = resync_q;
endmodule

// File: rtl/cmd_port_resync_chk.sv
`timescale 1ns/1ps
module cmd_port_resync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk_in,
  input logic       csn_in,
  input logic       sdi_in,
  input logic       tx_bit,
  input logic       sdo_o,
  input logic       sdo_oe,
  input logic       cmd_valid,
  input logic [7:0] cmd_byte,
  input logic       resync_pulse
);
  a_r4_float_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    csn_in |-> (!sdo_oe && !sdo_o));

  a_r4_drive_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !csn_in |-> (sdo_oe && sdo_o == tx_bit));

  a_r5_no_fill_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_byte != 8'hFF);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && resync_pulse));

  a_r11_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> $stable(cmd_byte));

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse);
endmodule

bind cmd_port_resync cmd_port_resync_chk i_chk (.*);

// File: tb/test_cmd_port_resync.sv
`timescale 1ns/1ps
module test_cmd_port_resync;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0, tx_bit = 1'b0;
  logic sdo_o, sdo_oe, cmd_valid, resync_pulse;
  logic [7:0] cmd_byte;

  always #2.5 clk = ~clk;

  cmd_port_resync i_cmd_port_resync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .csn_in(csn), .sdi_in(sdi),
    .tx_bit(tx_bit), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .resync_pulse(resync_pulse)
  );

  int checks = 0, failures = 0;
  int n_cmd = 0, n_res = 0;
  logic [7:0] last_cmd = 8'h00;

  // behavioural reference: run of ones, bit position, last eight bits
  int m_ones = 0, m_pos = 0;
  logic [7:0] m_acc = 8'h00;
  int ev_kind = 0;             // 0 none, 1 command, 2 resync
  logic [7:0] ev_byte = 8'h00;
  int d1k = 0, d2k = 0, d3k = 0;
  logic [7:0] d1b = 0, d2b = 0, d3b = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_bit(input logic b);
    if (csn) return;
    m_acc = {m_acc[6:0], b};
    if (!b && m_ones >= 127) begin
      ev_kind = 2; m_pos = 0; m_ones = 0;
    end else begin
      m_ones = b ? m_ones + 1 : 0;
      if (m_pos == 7) begin
        m_pos = 0;
        if (m_acc != 8'hFF) begin ev_kind = 1; ev_byte = m_acc; end
      end else m_pos++;
    end
  endtask

  // per-cycle comparison against the model, three clocks after the edge
  always @(negedge clk) begin
    chk("R4", "sdo_oe", int'(sdo_oe), int'(!csn));
    chk("R4", "sdo_o", int'(sdo_o), int'(tx_bit & !csn));
    chk("R2", "cmd_valid", int'(cmd_valid), int'(d3k == 1));
    chk("R6", "resync_pulse", int'(resync_pulse), int'(d3k == 2));
    if (d3k == 1) chk("R2", "cmd_byte", int'(cmd_byte), int'(d3b));
    if (cmd_valid) begin n_cmd++; last_cmd = cmd_byte; end
    if (resync_pulse) n_res++;
    d3k = d2k; d3b = d2b;
    d2k = d1k; d2b = d1b;
    d1k = ev_kind; d1b = ev_byte;
    ev_kind = 0;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    tick(HALF);
    sclk = 1'b1;
    model_bit(b);
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_sync(input int nff);
    for (int i = 0; i < nff; i++) send_byte(8'hFF);
    send_byte(8'hFE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0, r0;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "cmd_valid after reset", int'(cmd_valid), 0);
    chk("R1", "resync after reset", int'(resync_pulse), 0);
    chk("R1", "cmd_byte after reset", int'(cmd_byte), 0);
    chk("R4", "oe while deselected", int'(sdo_oe), 0);
    csn = 1'b0; tick(2 * HALF);

    // R6 and R5: aligned sync run
    c0 = n_cmd; r0 = n_res;
    send_sync(15); tick(8);
    chk("R6", "resync count", n_res - r0, 1);
    chk("R5", "fill not forwarded", n_cmd - c0, 0);

    // R2: plain bytes
    c0 = n_cmd;
    send_byte(8'hA5); tick(8);
    chk("R2", "byte A5", int'(last_cmd), 8'hA5);
    send_byte(8'h3C); tick(8);
    chk("R2", "byte 3C", int'(last_cmd), 8'h3C);
    chk("R2", "two commands", n_cmd - c0, 2);

    // R4: output follows tx_bit while selected
    tx_bit = 1'b1; #1;
    chk("R4", "sdo_o drives tx_bit", int'(sdo_o), 1);
    tx_bit = 1'b0;

    // R3: edges while deselected are ignored
    tick(2); csn = 1'b1; tick(2 * HALF);
    chk("R4", "oe low on deselect", int'(sdo_oe), 0);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    csn = 1'b0; tick(2 * HALF);
    c0 = n_cmd;
    send_byte(8'h66); tick(8);
    chk("R3", "alignment kept", int'(last_cmd), 8'h66);
    chk("R3", "one command", n_cmd - c0, 1);

    // R8: short run
    c0 = n_cmd; r0 = n_res;
    send_sync(14); tick(8);
    chk("R8", "no resync", n_res - r0, 0);
    chk("R8", "FE forwarded", int'(last_cmd), 8'hFE);
    chk("R8", "one command", n_cmd - c0, 1);

    // R7: long run
    c0 = n_cmd; r0 = n_res;
    send_sync(20); tick(8);
    chk("R7", "one resync", n_res - r0, 1);
    chk("R7", "nothing forwarded", n_cmd - c0, 0);

    // R10: run broken by another byte
    c0 = n_cmd; r0 = n_res;
    for (int i = 0; i < 7; i++) send_byte(8'hFF);
    send_byte(8'h12);
    send_sync(8); tick(8);
    chk("R10", "no resync", n_res - r0, 0);
    chk("R10", "two commands", n_cmd - c0, 2);
    chk("R10", "FE forwarded", int'(last_cmd), 8'hFE);

    // R9: misaligned run, then realigned byte
    c0 = n_cmd; r0 = n_res;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    send_sync(15); tick(8);
    chk("R9", "resync mid-byte", n_res - r0, 1);
    chk("R9", "partial byte forwarded", int'(last_cmd), 8'hBF);
    send_byte(8'h5A); tick(8);
    chk("R9", "realigned byte", int'(last_cmd), 8'h5A);
    chk("R9", "command count", n_cmd - c0, 2);

    tick(2); csn = 1'b1; tick(8);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule